// File: doc/BRIEF.md
# Device Link Out-of-Band and Power-State Controller

This block is the state machine on the device side of a high-speed serial storage link. It controls bring-up after power-on and after a reset signal from the host. It handles the partial and slumber low-power states and a pin-driven deep-sleep state. It also asks for a low-power state on its own when the link has gone quiet for too long. Detectors outside the block deliver single-cycle pulses for out-of-band (OOB) reset and wake signals seen on the receive pair. The block answers with single-cycle requests to a transmit sequencer that sends an init or a wake burst.

Bring-up runs in a fixed order. A reset from the host causes an init burst. The block then waits for the host's wake burst, runs a fixed calibration wait, sends its own wake burst and streams ALIGN primitives while a receive lock is pending. Streaming starts at the fastest speed index, and an external step-down pulse lowers it one index at a time. Lock ends streaming, raises PHY-ready and keeps the reached speed.

Waking from partial or slumber returns straight to PHY-ready at the kept speed, with no streaming. While the deep-sleep pin is high, the block ignores reset signals. When the pin falls, the block starts a fresh bring-up.

Top module: `dev_oob_pm_ctrl`

## Requirements
- R1: After reset, tx_init_o, tx_wake_o, align_tx_o, phy_rdy_o, pm_grant_o and pm_req_o are 0 and lp_state_o is 0 (lp_state_o codes: 0 active, 1 partial, 2 slumber, 3 deep sleep).
- R2: A rx_reset_det_i pulse while deep_sleep_i is low makes tx_init_o high for exactly the next cycle, from any state including PHY-ready, and drops phy_rdy_o.
- R3: After the init request, a rx_wake_det_i pulse starts a calibration wait, and tx_wake_o rises exactly CAL_CYC+1 cycles after the cycle in which the pulse was sampled.
- R4: In the cycle after the wake request, align_tx_o is high with spd_sel_o equal to NUM_SPD-1 (index 0 is the slowest speed); at most one of tx_init_o, tx_wake_o and align_tx_o is ever high.
- R5: Each step_down_i pulse during streaming lowers spd_sel_o by one, and the index stops at 0.
- R6: A lock_i pulse during streaming raises phy_rdy_o and lowers align_tx_o in the next cycle, and spd_sel_o keeps its value.
- R7: A pm_req_i pulse in PHY-ready gives a one-cycle pm_grant_o and, in the same cycle, lp_state_o equal to 2 if pm_slumber_i is 1 and 1 if it is 0, with phy_rdy_o low.
- R8: A rx_wake_det_i pulse in partial or slumber gives a one-cycle tx_wake_o, then phy_rdy_o with spd_sel_o unchanged and align_tx_o never raised.
- R9: A wake_req_i pulse in partial or slumber gives a one-cycle tx_wake_o; phy_rdy_o stays low until a rx_wake_det_i pulse, after which it rises at once and align_tx_o is never raised.
- R10: In PHY-ready with link_active_i low, pm_req_o rises exactly idle_limit_i+1 cycles after the last cycle with link_active_i high, with pm_req_slumber_o equal to idle_slumber_i. pm_ack_i then enters that low-power state and pm_nak_i returns to PHY-ready. The block never requests deep sleep itself.
- R11: deep_sleep_i high makes lp_state_o 3 with phy_rdy_o low in the next cycle, from any state.
- R12: While in deep sleep with deep_sleep_i high, a rx_reset_det_i pulse raises neither tx_init_o nor tx_wake_o, and lp_state_o stays 3.
- R13: When deep_sleep_i falls, tx_init_o is high in the next cycle and the following bring-up streams from spd_sel_o = NUM_SPD-1 again.
- R14: If deep_sleep_i and rx_reset_det_i are high in the same cycle, deep sleep wins: lp_state_o becomes 3 and tx_init_o stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_reset_det_i | input | 1 | Reset OOB signal detected from host (pulse) |
| rx_wake_det_i | input | 1 | Wake OOB signal detected from host (pulse) |
| deep_sleep_i | input | 1 | Host-driven deep-sleep pin |
| lock_i | input | 1 | Receive side locked during streaming (pulse) |
| step_down_i | input | 1 | Lower the streaming speed by one index (pulse) |
| link_active_i | input | 1 | Link traffic seen this cycle |
| pm_req_i | input | 1 | Host asks for a low-power state (pulse) |
| pm_slumber_i | input | 1 | Host request kind: 1 slumber, 0 partial |
| pm_ack_i | input | 1 | Host accepts the block's own request |
| pm_nak_i | input | 1 | Host refuses the block's own request |
| wake_req_i | input | 1 | Local wish to leave partial or slumber (pulse) |
| idle_slumber_i | input | 1 | Kind of self-request after idle: 1 slumber, 0 partial |
| idle_limit_i | input | IDLE_W | Idle timeout in cycles |
| tx_init_o | output | 1 | Send an init OOB burst |
| tx_wake_o | output | 1 | Send a wake OOB burst |
| align_tx_o | output | 1 | Stream ALIGN primitives |
| spd_sel_o | output | SPD_W | Speed index, 0 slowest |
| phy_rdy_o | output | 1 | PHY ready |
| lp_state_o | output | 2 | Power state code |
| pm_grant_o | output | 1 | Host low-power request granted (pulse) |
| pm_req_o | output | 1 | Block asks host for low power |
| pm_req_slumber_o | output | 1 | Kind of the block's request: 1 slumber |

## Verification
Two functions can fall in the same cycle: entry into deep sleep and a forced return to bring-up on a host reset. Either can also coincide with any other transition. The bench raises deep_sleep_i and rx_reset_det_i on the same edge while the link is ready. It then expects lp_state_o to read 3 and tx_init_o to stay low, so the pin must win over the reset. It also sends a host reset during an established deep sleep and requires silence on every transmit request for as long as the pin stays high.

// File: rtl/dlpm_pkg.sv
package dlpm_pkg;

   typedef enum logic [3:0] {
      ST_OFF,
      ST_INIT_TX,
      ST_WAIT_WAKE,
      ST_CALIB,
      ST_WAKE_TX,
      ST_ALIGN,
      ST_READY,
      ST_PM_REQ,
      ST_LP,
      ST_LWAKE_TX,
      ST_LWAKE_WAIT,
      ST_RWAKE_TX,
      ST_SLEEP
   } dlpm_state_e;

   localparam logic [1:0] LP_ACTIVE  = 2'd0;
   localparam logic [1:0] LP_PARTIAL = 2'd1;
   localparam logic [1:0] LP_SLUMBER = 2'd2;
   localparam logic [1:0] LP_DEEP    = 2'd3;

endpackage

// File: rtl/dlpm_timer.sv
module dlpm_timer #(
   parameter int CNT_W = 8
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             clr_i,
   input  logic             en_i,
   input  logic [CNT_W-1:0] lim_i,
   output logic             done_o
);

   generate
      if (CNT_W < 1) begin : g_bad_w
         $error("dlpm_timer: CNT_W must be at least 1");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;

   assign done_o = (cnt_q >= lim_i);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
      end else if (clr_i) begin
         cnt_q <= '0;
      end else if (en_i && !done_o) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

endmodule

// File: rtl/dlpm_speed.sv
module dlpm_speed #(
   parameter int NUM_SPD = 3,
   parameter int SPD_W   = 2
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             load_max_i,
   input  logic             step_i,
   output logic [SPD_W-1:0] spd_o
);

   localparam logic [SPD_W-1:0] SPD_MAX = SPD_W'(NUM_SPD - 1);

   generate
      if (NUM_SPD < 1) begin : g_bad_n
         $error("dlpm_speed: NUM_SPD must be at least 1");
      end
      if ((1 << SPD_W) < NUM_SPD) begin : g_bad_w
         $error("dlpm_speed: SPD_W too narrow for NUM_SPD");
      end
   endgenerate

   logic [SPD_W-1:0] spd_q;

   assign spd_o = spd_q;

   generate
      if (NUM_SPD == 1) begin : g_single
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               spd_q <= SPD_MAX;
            end else if (load_max_i || step_i) begin
               spd_q <= SPD_MAX;
            end
         end
      end else begin : g_multi
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               spd_q <= SPD_MAX;
            end else if (load_max_i) begin
               spd_q <= SPD_MAX;
            end else if (step_i && (spd_q != '0)) begin
               spd_q <= spd_q - 1'b1;
            end
         end
      end
   endgenerate

endmodule

// File: rtl/dlpm_fsm.sv
module dlpm_fsm
   import dlpm_pkg::*;
(
   input  logic        clk_i,
   input  logic        rst_ni,
   input  logic        rx_reset_i,
   input  logic        rx_wake_i,
   input  logic        deep_sleep_i,
   input  logic        lock_i,
   input  logic        pm_req_i,
   input  logic        pm_slumber_i,
   input  logic        pm_ack_i,
   input  logic        pm_nak_i,
   input  logic        wake_req_i,
   input  logic        idle_slumber_i,
   input  logic        cal_done_i,
   input  logic        idle_done_i,
   output dlpm_state_e state_o,
   output logic        slumber_o,
   output logic        grant_o
);

   dlpm_state_e st_q, st_d;
   logic        mode_q, mode_d;
   logic        grant_q, grant_d;

   always_comb begin
      st_d    = st_q;
      mode_d  = mode_q;
      grant_d = 1'b0;
      if (deep_sleep_i) begin
         st_d = ST_SLEEP;
      end else if (rx_reset_i) begin
         st_d = ST_INIT_TX;
      end else begin
         unique case (st_q)
            ST_OFF:        st_d = ST_OFF;
            ST_INIT_TX:    st_d = ST_WAIT_WAKE;
            ST_WAIT_WAKE:  if (rx_wake_i) st_d = ST_CALIB;
            ST_CALIB:      if (cal_done_i) st_d = ST_WAKE_TX;
            ST_WAKE_TX:    st_d = ST_ALIGN;
            ST_ALIGN:      if (lock_i) st_d = ST_READY;
            ST_READY: begin
               if (pm_req_i) begin
                  st_d    = ST_LP;
                  mode_d  = pm_slumber_i;
                  grant_d = 1'b1;
               end else if (idle_done_i) begin
                  st_d   = ST_PM_REQ;
                  mode_d = idle_slumber_i;
               end
            end
            ST_PM_REQ: begin
               if (pm_ack_i) begin
                  st_d = ST_LP;
               end else if (pm_nak_i) begin
                  st_d = ST_READY;
               end
            end
            ST_LP: begin
               if (rx_wake_i) begin
                  st_d = ST_RWAKE_TX;
               end else if (wake_req_i) begin
                  st_d = ST_LWAKE_TX;
               end
            end
            ST_LWAKE_TX:   st_d = ST_LWAKE_WAIT;
            ST_LWAKE_WAIT: if (rx_wake_i) st_d = ST_READY;
            ST_RWAKE_TX:   st_d = ST_READY;
            ST_SLEEP:      st_d = ST_INIT_TX;
            default:       st_d = ST_OFF;
         endcase
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         st_q    <= ST_OFF;
         mode_q  <= 1'b0;
         grant_q <= 1'b0;
      end else begin
         st_q    <= st_d;
         mode_q  <= mode_d;
         grant_q <= grant_d;
      end
   end

   assign state_o   = st_q;
   assign slumber_o = mode_q;
   assign grant_o   = grant_q;

endmodule

// File: rtl/dev_oob_pm_ctrl.sv
module dev_oob_pm_ctrl
   import dlpm_pkg::*;
#(
   parameter int NUM_SPD   = 3,
   parameter int CAL_CYC   = 16,
   parameter int IDLE_W    = 16,
   parameter bit IDLE_PROG = 1'b1,
   parameter int IDLE_CYC  = 1000,
   localparam int SPD_W    = (NUM_SPD > 1) ? $clog2(NUM_SPD) : 1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              rx_reset_det_i,
   input  logic              rx_wake_det_i,
   input  logic              deep_sleep_i,
   input  logic              lock_i,
   input  logic              step_down_i,
   input  logic              link_active_i,
   input  logic              pm_req_i,
   input  logic              pm_slumber_i,
   input  logic              pm_ack_i,
   input  logic              pm_nak_i,
   input  logic              wake_req_i,
   input  logic              idle_slumber_i,
   input  logic [IDLE_W-1:0] idle_limit_i,
   output logic              tx_init_o,
   output logic              tx_wake_o,
   output logic              align_tx_o,
   output logic [SPD_W-1:0]  spd_sel_o,
   output logic              phy_rdy_o,
   output logic [1:0]        lp_state_o,
   output logic              pm_grant_o,
   output logic              pm_req_o,
   output logic              pm_req_slumber_o
);

   localparam int CAL_W = $clog2(CAL_CYC + 1);

   generate
      if (CAL_CYC < 1) begin : g_bad_cal
         $error("dev_oob_pm_ctrl: CAL_CYC must be at least 1");
      end
      if (IDLE_W < 2) begin : g_bad_idle_w
         $error("dev_oob_pm_ctrl: IDLE_W must be at least 2");
      end
      if (!IDLE_PROG && (IDLE_CYC >= (1 << IDLE_W))) begin : g_bad_idle_cyc
         $error("dev_oob_pm_ctrl: IDLE_CYC does not fit IDLE_W");
      end
   endgenerate

   dlpm_state_e state;
   logic        slumber;
   logic        cal_done, idle_done;
   logic [IDLE_W-1:0] idle_lim;

   generate
      if (IDLE_PROG) begin : g_idle_prog
         assign idle_lim = idle_limit_i;
      end else begin : g_idle_fixed
         assign idle_lim = IDLE_W'(IDLE_CYC);
      end
   endgenerate

   dlpm_fsm i_fsm (
      .clk_i          (clk_i),
      .rst_ni         (rst_ni),
      .rx_reset_i     (rx_reset_det_i),
      .rx_wake_i      (rx_wake_det_i),
      .deep_sleep_i   (deep_sleep_i),
      .lock_i         (lock_i),
      .pm_req_i       (pm_req_i),
      .pm_slumber_i   (pm_slumber_i),
      .pm_ack_i       (pm_ack_i),
      .pm_nak_i       (pm_nak_i),
      .wake_req_i     (wake_req_i),
      .idle_slumber_i (idle_slumber_i),
      .cal_done_i     (cal_done),
      .idle_done_i    (idle_done),
      .state_o        (state),
      .slumber_o      (slumber),
      .grant_o        (pm_grant_o)
   );

   dlpm_timer #(.CNT_W(CAL_W)) i_cal_tmr (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (state != ST_CALIB),
      .en_i   (state == ST_CALIB),
      .lim_i  (CAL_W'(CAL_CYC)),
      .done_o (cal_done)
   );

   dlpm_timer #(.CNT_W(IDLE_W)) i_idle_tmr (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  ((state != ST_READY) || link_active_i),
      .en_i   (state == ST_READY),
      .lim_i  (idle_lim),
      .done_o (idle_done)
   );

   dlpm_speed #(.NUM_SPD(NUM_SPD), .SPD_W(SPD_W)) i_speed (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .load_max_i (state == ST_INIT_TX),
      .step_i     ((state == ST_ALIGN) && step_down_i),
      .spd_o      (spd_sel_o)
   );

   logic in_lp;
   assign in_lp = (state == ST_LP) || (state == ST_LWAKE_TX) ||
                  (state == ST_LWAKE_WAIT) || (state == ST_RWAKE_TX);

   assign tx_init_o        = (state == ST_INIT_TX);
   assign tx_wake_o        = (state == ST_WAKE_TX) || (state == ST_LWAKE_TX) ||
                             (state == ST_RWAKE_TX);
   assign align_tx_o       = (state == ST_ALIGN);
   assign phy_rdy_o        = (state == ST_READY) || (state == ST_PM_REQ);
   assign pm_req_o         = (state == ST_PM_REQ);
   assign pm_req_slumber_o = (state == ST_PM_REQ) && slumber;

   always_comb begin
      if (state == ST_SLEEP) begin
         lp_state_o = LP_DEEP;
      end else if (in_lp) begin
         lp_state_o = slumber ? LP_SLUMBER : LP_PARTIAL;
      end else begin
         lp_state_o = LP_ACTIVE;
      end
   end

endmodule

// File: rtl/dev_oob_pm_chk.sv
module dev_oob_pm_chk #(
   parameter int NUM_SPD = 3,
   localparam int SPD_W  = (NUM_SPD > 1) ? $clog2(NUM_SPD) : 1
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             rx_reset_det_i,
   input logic             deep_sleep_i,
   input logic             tx_init_o,
   input logic             tx_wake_o,
   input logic             align_tx_o,
   input logic [SPD_W-1:0] spd_sel_o,
   input logic             phy_rdy_o,
   input logic [1:0]       lp_state_o,
   input logic             pm_grant_o,
   input logic             pm_req_o
);

   // R2
   rst_answer_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rx_reset_det_i && !deep_sleep_i) |=> tx_init_o);

   // R11
   sleep_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      deep_sleep_i |=> (lp_state_o == 2'd3 && !phy_rdy_o));

   // R12
   sleep_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (deep_sleep_i && lp_state_o == 2'd3) |=> (!tx_init_o && !tx_wake_o));

   // R14
   sleep_prio_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (deep_sleep_i && rx_reset_det_i) |=> !tx_init_o);

   // R4
   tx_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0({tx_init_o, tx_wake_o, align_tx_o}));

   // R6
   rdy_clean_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      phy_rdy_o |-> (!align_tx_o && !tx_init_o && lp_state_o == 2'd0));

   // R8
   spd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((lp_state_o == 2'd1 || lp_state_o == 2'd2) && !deep_sleep_i && !rx_reset_det_i)
      |=> $stable(spd_sel_o));

   // R7
   grant_lp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pm_grant_o |-> (lp_state_o == 2'd1 || lp_state_o == 2'd2));

   // R10
   self_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pm_req_o |-> (lp_state_o == 2'd0 && phy_rdy_o));

endmodule

bind dev_oob_pm_ctrl dev_oob_pm_chk #(.NUM_SPD(NUM_SPD)) i_chk (
   .clk_i          (clk_i),
   .rst_ni         (rst_ni),
   .rx_reset_det_i (rx_reset_det_i),
   .deep_sleep_i   (deep_sleep_i),
   .tx_init_o      (tx_init_o),
   .tx_wake_o      (tx_wake_o),
   .align_tx_o     (align_tx_o),
   .spd_sel_o      (spd_sel_o),
   .phy_rdy_o      (phy_rdy_o),
   .lp_state_o     (lp_state_o),
   .pm_grant_o     (pm_grant_o),
   .pm_req_o       (pm_req_o)
);

// File: tb/test_dev_oob_pm_ctrl.sv
`timescale 1ns/1ps
module test_dev_oob_pm_ctrl;

   localparam int NSPD = 3;
   localparam int CAL  = 8;
   localparam int IW   = 16;
   localparam int SW   = 2;

   localparam int P_RST  = 0;
   localparam int P_WAKE = 1;
   localparam int P_LOCK = 2;
   localparam int P_STEP = 3;
   localparam int P_ACT  = 4;
   localparam int P_PMR  = 5;
   localparam int P_ACK  = 6;
   localparam int P_NAK  = 7;
   localparam int P_WREQ = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic rx_reset = 0, rx_wake = 0, deep_sleep = 0, lock = 0, step_down = 0;
   logic link_active = 0, pm_req = 0, pm_slumber = 0, pm_ack = 0, pm_nak = 0;
   logic wake_req = 0, idle_slumber = 0;
   logic [IW-1:0] idle_limit = 16'd60000;
   logic tx_init, tx_wake, align_tx, phy_rdy, pm_grant, pm_req_out, pm_req_slb;
   logic [SW-1:0] spd_sel;
   logic [1:0] lp_state;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   dev_oob_pm_ctrl #(.NUM_SPD(NSPD), .CAL_CYC(CAL), .IDLE_W(IW)) i_dev_oob_pm_ctrl (
      .clk_i(clk), .rst_ni(rst_n),
      .rx_reset_det_i(rx_reset), .rx_wake_det_i(rx_wake), .deep_sleep_i(deep_sleep),
      .lock_i(lock), .step_down_i(step_down), .link_active_i(link_active),
      .pm_req_i(pm_req), .pm_slumber_i(pm_slumber), .pm_ack_i(pm_ack), .pm_nak_i(pm_nak),
      .wake_req_i(wake_req), .idle_slumber_i(idle_slumber), .idle_limit_i(idle_limit),
      .tx_init_o(tx_init), .tx_wake_o(tx_wake), .align_tx_o(align_tx), .spd_sel_o(spd_sel),
      .phy_rdy_o(phy_rdy), .lp_state_o(lp_state), .pm_grant_o(pm_grant),
      .pm_req_o(pm_req_out), .pm_req_slumber_o(pm_req_slb));

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic chk_eq(input string req, input int act, input int exp);
      chk(act == exp, req, act, exp);
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic drive(input int w, input logic v);
      case (w)
         P_RST:  rx_reset    = v;
         P_WAKE: rx_wake     = v;
         P_LOCK: lock        = v;
         P_STEP: step_down   = v;
         P_ACT:  link_active = v;
         P_PMR:  pm_req      = v;
         P_ACK:  pm_ack      = v;
         P_NAK:  pm_nak      = v;
         P_WREQ: wake_req    = v;
         default: ;
      endcase
   endtask

   task automatic pulse(input int w);
      drive(w, 1'b1);
      tick();
      drive(w, 1'b0);
   endtask

   // wake pulse seen, then count cycles to the wake request (R3) and check streaming (R4)
   task automatic calib_and_stream(input string tag);
      int k;
      pulse(P_WAKE);
      k = 0;
      while (!tx_wake && k < 100) begin
         tick();
         k++;
      end
      chk_eq({"R3 calib length ", tag}, k, CAL + 1);
      tick();
      chk(align_tx && !tx_wake && !phy_rdy, {"R4 streaming ", tag}, int'(align_tx), 1);
      chk_eq({"R4 top speed ", tag}, int'(spd_sel), NSPD - 1);
   endtask

   task automatic t_reset();
      chk(!tx_init && !tx_wake && !align_tx && !phy_rdy && !pm_grant && !pm_req_out,
          "R1 outputs idle", int'(phy_rdy), 0);
      chk_eq("R1 lp code", int'(lp_state), 0);
   endtask

   task automatic t_power_on();
      pulse(P_RST);
      chk_eq("R2 init request", int'(tx_init), 1);
      tick();
      chk_eq("R2 init one cycle", int'(tx_init), 0);
      calib_and_stream("power-on");
      pulse(P_STEP);
      chk_eq("R5 step 1", int'(spd_sel), NSPD - 2);
      pulse(P_STEP);
      chk_eq("R5 step 2", int'(spd_sel), 0);
      pulse(P_STEP);
      chk_eq("R5 floor", int'(spd_sel), 0);
      pulse(P_LOCK);
      chk(phy_rdy && !align_tx, "R6 ready after lock", int'(phy_rdy), 1);
      chk_eq("R6 speed kept", int'(spd_sel), 0);
   endtask

   task automatic t_host_pm();
      pm_slumber = 1'b1;
      pulse(P_PMR);
      chk(pm_grant && !phy_rdy, "R7 grant slumber", int'(pm_grant), 1);
      chk_eq("R7 slumber code", int'(lp_state), 2);
      tick();
      chk_eq("R7 grant one cycle", int'(pm_grant), 0);
      pulse(P_WAKE);
      chk(tx_wake && !align_tx, "R8 remote wake answer", int'(tx_wake), 1);
      tick();
      chk(phy_rdy && !align_tx, "R8 ready without streaming", int'(phy_rdy), 1);
      chk_eq("R8 speed kept", int'(spd_sel), 0);
      pm_slumber = 1'b0;
      pulse(P_PMR);
      chk_eq("R7 partial code", int'(lp_state), 1);
      tick();
      pulse(P_WREQ);
      chk_eq("R9 local wake burst", int'(tx_wake), 1);
      tick();
      chk(!tx_wake && !phy_rdy && lp_state == 2'd1, "R9 waits for host", int'(phy_rdy), 0);
      tick();
      chk_eq("R9 still waiting", int'(phy_rdy), 0);
      pulse(P_WAKE);
      chk(phy_rdy && !align_tx, "R9 ready on host wake", int'(phy_rdy), 1);
      chk_eq("R9 speed kept", int'(spd_sel), 0);
   endtask

   task automatic t_idle();
      int k;
      idle_limit   = 16'd20;
      idle_slumber = 1'b1;
      pulse(P_ACT);
      k = 0;
      while (!pm_req_out && k < 200) begin
         tick();
         k++;
      end
      chk_eq("R10 idle timeout", k, 21);
      chk(pm_req_slb && lp_state == 2'd0, "R10 request kind slumber", int'(pm_req_slb), 1);
      pulse(P_ACK);
      chk(lp_state == 2'd2 && !pm_req_out, "R10 ack enters slumber", int'(lp_state), 2);
      pulse(P_WAKE);
      tick();
      chk_eq("R10 back ready", int'(phy_rdy), 1);
      idle_slumber = 1'b0;
      pulse(P_ACT);
      repeat (10) tick();
      chk_eq("R10 no early request", int'(pm_req_out), 0);
      pulse(P_ACT);
      k = 0;
      while (!pm_req_out && k < 200) begin
         tick();
         k++;
      end
      chk_eq("R10 timeout restarted by activity", k, 21);
      chk_eq("R10 request kind partial", int'(pm_req_slb), 0);
      idle_limit = 16'd60000;
      pulse(P_NAK);
      chk(phy_rdy && !pm_req_out && lp_state == 2'd0, "R10 nak keeps ready",
          int'(phy_rdy), 1);
   endtask

   task automatic t_reset_in_ready();
      pulse(P_RST);
      chk(tx_init && !phy_rdy, "R2 reset from ready", int'(tx_init), 1);
      tick();
      calib_and_stream("after reset");
      pulse(P_LOCK);
      chk_eq("R6 ready again", int'(phy_rdy), 1);
   endtask

   task automatic t_sleep();
      deep_sleep = 1'b1;
      tick();
      chk(lp_state == 2'd3 && !phy_rdy, "R11 deep sleep entry", int'(lp_state), 3);
      pulse(P_RST);
      chk(!tx_init && !tx_wake && lp_state == 2'd3, "R12 reset ignored", int'(tx_init), 0);
      repeat (3) tick();
      chk(!tx_init && lp_state == 2'd3, "R12 still asleep", int'(lp_state), 3);
      deep_sleep = 1'b0;
      tick();
      chk(tx_init && lp_state == 2'd0, "R13 exit starts init", int'(tx_init), 1);
      tick();
      calib_and_stream("R13 after sleep");
      pulse(P_LOCK);
      chk_eq("R13 ready again", int'(phy_rdy), 1);
      deep_sleep = 1'b1;
      rx_reset   = 1'b1;
      tick();
      rx_reset = 1'b0;
      chk(lp_state == 2'd3 && !tx_init, "R14 sleep beats reset", int'(lp_state), 3);
      deep_sleep = 1'b0;
      tick();
      chk_eq("R13 init after second exit", int'(tx_init), 1);
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (3) tick();
      rst_n = 1'b1;
      tick();
      t_reset();
      t_power_on();
      t_host_pm();
      t_idle();
      t_reset_in_ready();
      t_sleep();
      repeat (2) tick();
      summary();
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      summary();
   end

endmodule